// File: doc/BRIEF.md
# Flash Line ECC Error Reporter

This block watches the read path of a flash array that always fetches a whole 128-bit line. The line is made of two 64-bit double words. Double word A is the lower one, at byte offset 0 to 7. Double word B is the upper one, at byte offset 8 to 15. Each half arrives with its own ECC verdict: clean, corrected single-bit, or uncorrectable. The requesting byte address arrives with the verdicts. The block folds these verdicts into two sticky flags and one first-failing-address register. It also tells the requester when its read must end in a bus error.

The flags look at the whole fetched line, not only at the requested half. The bus error looks only at the half that was addressed. So status can show an uncorrectable error even though the requester saw a clean completion. A handler that reads the status therefore has to compare the recorded address with the address it faulted on. Software clears the flags by writing ones to a clear mask. The recorded address is then frozen until every flag has been cleared.

Top module: `flash_ecc_reporter`

## Requirements
- R1: Synchronous active-low reset drives `bus_err`, `ue_flag` and `sbc_flag` to 0 and `fail_addr` to 0.
- R2: A read (`rd_valid`=1) sets `ue_flag` on the next clock edge if either half reports uncorrectable. The verdict codes are 2'b00 clean, 2'b01 corrected, and 2'b1x uncorrectable. Half A sits at `rd_ecc[1:0]` and half B at `rd_ecc[3:2]`.
- R3: `bus_err` is high for exactly the cycle after a read whose addressed half is uncorrectable, and low otherwise. The addressed half is selected by `rd_addr[3]` (0 = A, 1 = B). An uncorrectable error only in the other half gives no bus error.
- R4: `ue_flag` stays set until a write with `clr_wr`=1 and `clr_mask[0]`=1, or until reset.
- R5: A corrected verdict in either half of a read sets `sbc_flag` on the next edge and never raises `bus_err`. `sbc_flag` is cleared only by `clr_wr` with `clr_mask[1]`=1, or by reset.
- R6: When a read carries any non-clean verdict and no flag stays set through that cycle, `fail_addr` captures the byte address of the failing double word. That address is the line base (`rd_addr` with bits [3:0] zeroed) plus 8 times the half index. It may differ from `rd_addr`.
- R7: If both halves of one read report a non-clean verdict, `fail_addr` records half A.
- R8: While either flag is set and is not cleared in that cycle, `fail_addr` holds its value. A clear that leaves no flag set, with no new event, also leaves `fail_addr` unchanged.
- R9: A new error in the same cycle as a clear of its flag wins: the flag stays set. If the clear empties every flag, `fail_addr` takes the new event's address.
- R10: When `rd_valid`=0, `rd_addr` and `rd_ecc` have no effect on any output.
- R11: Clearing one flag leaves the other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | A line read completes this cycle |
| rd_addr | input | ADDR_W | Requested byte address |
| rd_ecc | input | 2*LINE_BYTES/DW_BYTES | Per-half ECC verdicts, two bits per half, half 0 lowest |
| clr_wr | input | 1 | Write strobe for the clear mask |
| clr_mask | input | 2 | Write-one-to-clear: bit 0 uncorrectable flag, bit 1 correction flag |
| bus_err | output | 1 | Bus error for the read of the previous cycle |
| ue_flag | output | 1 | Sticky uncorrectable-error flag |
| sbc_flag | output | 1 | Sticky single-bit-correction flag |
| fail_addr | output | ADDR_W | Address of the first failing double word |

## Verification
Reads are driven with the error in the addressed half, in the other half only, and in both halves. These three cases separate the line-wide flag path from the addressed-half bus error path, and they also check that half A wins when both halves fail. Clears are issued alone, one flag at a time, and in the same cycle as a new error. This shows the flag priority and shows when the address register is released. Idle cycles carry error verdicts to prove that the read qualifier gates every input. A long run of random reads, addresses and clears is then compared on every clock against a behavioural model.

// File: rtl/flash_ecc_pkg.sv
// Shared types for the flash line ECC error reporter.
// Assumes a two-bit verdict per double word; any code with bit 1 set is fatal.
package flash_ecc_pkg;

    typedef enum logic [1:0] {
        VERDICT_CLEAN   = 2'b00,
        VERDICT_FIXED   = 2'b01,
        VERDICT_FATAL   = 2'b10,
        VERDICT_FATAL_X = 2'b11
    } ecc_verdict_e;

    localparam int VERDICT_W  = 2;
    localparam int CLR_UE_BIT = 0;
    localparam int CLR_CE_BIT = 1;
    localparam int CLR_W      = 2;

endpackage

// File: rtl/flash_ecc_half_decode.sv
// Splits the packed per-half verdict vector into fatal and corrected masks.
// Assumes verdicts are packed with half 0 (lowest address) in the lowest bits.
module flash_ecc_half_decode
    import flash_ecc_pkg::*;
#(
    parameter int HALVES = 2
) (
    input  logic [VERDICT_W*HALVES-1:0] ecc_vec,
    output logic [HALVES-1:0]           fatal_v,
    output logic [HALVES-1:0]           fixed_v
);

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ecc_verdict_e verdict;

        // Classify one half's verdict
        always_comb begin
            verdict    = ecc_verdict_e'(ecc_vec[h*VERDICT_W +: VERDICT_W]);
            fatal_v[h] = (verdict == VERDICT_FATAL) || (verdict == VERDICT_FATAL_X);
            fixed_v[h] = (verdict == VERDICT_FIXED);
        end
    end

endmodule

// File: rtl/flash_ecc_fail_pick.sv
// Picks the lowest failing double word of a line and forms its byte address.
// Assumes LINE_BYTES and DW_BYTES are powers of two.
module flash_ecc_fail_pick #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int DW_BYTES   = 8
) (
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [LINE_BYTES/DW_BYTES-1:0]   hit_v,
    output logic                             any_hit,
    output logic [ADDR_W-1:0]                pick_addr
);

    localparam int HALVES = LINE_BYTES / DW_BYTES;
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] half_off;

    // Lowest set hit wins: scan from the top so the lowest assignment stays
    always_comb begin
        line_base = rd_addr & ~LINE_MASK;
        half_off  = '0;
        any_hit   = 1'b0;
        for (int h = HALVES - 1; h >= 0; h--) begin
            if (hit_v[h]) begin
                half_off = ADDR_W'(h * DW_BYTES);
                any_hit  = 1'b1;
            end
        end
        pick_addr = line_base | half_off;
    end

endmodule

// File: rtl/flash_ecc_status_regs.sv
// Sticky error flags with write-one-to-clear, and the first-failing-address register.
// Assumes set requests beat clears in the same cycle; the address is held while any flag stays set.
module flash_ecc_status_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ue,
    input  logic              set_ce,
    input  logic              clr_ue,
    input  logic              clr_ce,
    input  logic              cap_req,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic              ue_q,
    output logic              ce_q,
    output logic [ADDR_W-1:0] addr_q
);

    logic ue_keep;
    logic ce_keep;

    // Flags that survive this cycle's clear
    always_comb begin
        ue_keep = ue_q & ~clr_ue;
        ce_keep = ce_q & ~clr_ce;
    end

    // Sticky flags: a new event outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ue_q <= 1'b0;
            ce_q <= 1'b0;
        end else begin
            ue_q <= ue_keep | set_ue;
            ce_q <= ce_keep | set_ce;
        end
    end

    // Address capture only when no flag remains set after clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cap_req && !ue_keep && !ce_keep) begin
            addr_q <= cap_addr;
        end
    end

endmodule

// File: rtl/flash_ecc_reporter.sv
// Top of the flash line ECC error reporter.
// Flags cover the whole fetched line; the bus error covers only the addressed double word.
// Assumes one line read per cycle at most, qualified by rd_valid.
module flash_ecc_reporter
    import flash_ecc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int DW_BYTES   = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      rd_valid,
    input  logic [ADDR_W-1:0]                         rd_addr,
    input  logic [VERDICT_W*(LINE_BYTES/DW_BYTES)-1:0] rd_ecc,
    input  logic                                      clr_wr,
    input  logic [CLR_W-1:0]                          clr_mask,
    output logic                                      bus_err,
    output logic                                      ue_flag,
    output logic                                      sbc_flag,
    output logic [ADDR_W-1:0]                         fail_addr
);

    localparam int HALVES = LINE_BYTES / DW_BYTES;
    localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int DW_LSB = $clog2(DW_BYTES);

    logic [HALVES-1:0] fatal_v;
    logic [HALVES-1:0] fixed_v;
    logic [HALVES-1:0] event_v;
    logic              any_event;
    logic [ADDR_W-1:0] pick_addr;
    logic [HSEL_W-1:0] sel_half;
    logic              sel_fatal;
    logic              bus_err_q;

    flash_ecc_half_decode #(.HALVES(HALVES)) u_decode (
        .ecc_vec (rd_ecc),
        .fatal_v (fatal_v),
        .fixed_v (fixed_v)
    );

    // Any non-clean verdict is an ECC event for address capture
    always_comb begin
        event_v   = fatal_v | fixed_v;
        sel_half  = rd_addr[DW_LSB +: HSEL_W];
        sel_fatal = fatal_v[sel_half];
    end

    flash_ecc_fail_pick #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .DW_BYTES   (DW_BYTES)
    ) u_pick (
        .rd_addr   (rd_addr),
        .hit_v     (event_v),
        .any_hit   (any_event),
        .pick_addr (pick_addr)
    );

    flash_ecc_status_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ue   (rd_valid & (|fatal_v)),
        .set_ce   (rd_valid & (|fixed_v)),
        .clr_ue   (clr_wr & clr_mask[CLR_UE_BIT]),
        .clr_ce   (clr_wr & clr_mask[CLR_CE_BIT]),
        .cap_req  (rd_valid & any_event),
        .cap_addr (pick_addr),
        .ue_q     (ue_flag),
        .ce_q     (sbc_flag),
        .addr_q   (fail_addr)
    );

    // Bus error response for the addressed half only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err_q <= 1'b0;
        end else begin
            bus_err_q <= rd_valid & sel_fatal;
        end
    end

    assign bus_err = bus_err_q;

endmodule

// File: rtl/flash_ecc_reporter_chk.sv
// Property checker for flash_ecc_reporter, attached by bind below.
// Assumes the default verdict packing: two bits per half, bit 1 set means uncorrectable.
module flash_ecc_reporter_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int DW_BYTES   = 8
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  rd_valid,
    input logic [ADDR_W-1:0]                     rd_addr,
    input logic [2*(LINE_BYTES/DW_BYTES)-1:0]    rd_ecc,
    input logic                                  clr_wr,
    input logic [1:0]                            clr_mask,
    input logic                                  bus_err,
    input logic                                  ue_flag,
    input logic                                  sbc_flag,
    input logic [ADDR_W-1:0]                     fail_addr
);

    localparam int HALVES = LINE_BYTES / DW_BYTES;
    localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1;
    localparam int DW_LSB = $clog2(DW_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic any_fatal;
    logic any_event;
    logic sel_fatal;
    logic [HSEL_W-1:0] sel_half;

    // Independent summary of the incoming verdicts
    always_comb begin
        any_fatal = 1'b0;
        any_event = 1'b0;
        for (int h = 0; h < HALVES; h++) begin
            any_fatal = any_fatal | rd_ecc[2*h+1];
            any_event = any_event | rd_ecc[2*h+1] | rd_ecc[2*h];
        end
        sel_half  = rd_addr[DW_LSB +: HSEL_W];
        sel_fatal = rd_ecc[2*sel_half+1];
    end

    // R2
    ue_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && any_fatal |=> ue_flag);

    // R3
    berr_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && sel_fatal |=> bus_err);

    // R3
    berr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && sel_fatal) |=> !bus_err);

    // R3
    berr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ue_flag);

    // R4
    ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ue_flag && !(clr_wr && clr_mask[0]) |=> ue_flag);

    // R6
    cap_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && any_event && !ue_flag && !sbc_flag
        |=> (fail_addr & ~LINE_MASK) == ($past(rd_addr) & ~LINE_MASK));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag || sbc_flag) && !clr_wr |=> $stable(fail_addr));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid && !clr_wr |=> $stable(ue_flag) && $stable(sbc_flag) && $stable(fail_addr) && !bus_err);

endmodule

bind flash_ecc_reporter flash_ecc_reporter_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .DW_BYTES   (DW_BYTES)
) u_chk (.*);

// File: tb/sim_flash_ecc_reporter.sv
// Bench for flash_ecc_reporter: a behavioural model is stepped each clock and compared.
module sim_flash_ecc_reporter;

    localparam int PERIOD = 10;
    localparam int LIMIT  = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [3:0]  rd_ecc = '0;
    logic        clr_wr = 1'b0;
    logic [1:0]  clr_mask = '0;
    logic        bus_err;
    logic        ue_flag;
    logic        sbc_flag;
    logic [31:0] fail_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic        m_berr = 1'b0;
    logic        m_ue = 1'b0;
    logic        m_ce = 1'b0;
    logic [31:0] m_addr = '0;

    flash_ecc_reporter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_ecc    (rd_ecc),
        .clr_wr    (clr_wr),
        .clr_mask  (clr_mask),
        .bus_err   (bus_err),
        .ue_flag   (ue_flag),
        .sbc_flag  (sbc_flag),
        .fail_addr (fail_addr)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) cycles++;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "bus_err",   32'(bus_err),  32'(m_berr));
        check(tag, "ue_flag",   32'(ue_flag),  32'(m_ue));
        check(tag, "sbc_flag",  32'(sbc_flag), 32'(m_ce));
        check(tag, "fail_addr", fail_addr,     m_addr);
    endtask

    // Drive one cycle, advance the model at the edge, compare a quarter period later
    task automatic step(input logic v, input logic [31:0] a, input logic [1:0] ea, input logic [1:0] eb,
                        input logic cw, input logic [1:0] cm, input string tag);
        logic keep_ue, keep_ce, hit_a, hit_b;
        rd_valid = v; rd_addr = a; rd_ecc = {eb, ea}; clr_wr = cw; clr_mask = cm;
        @(posedge clk);
        keep_ue = m_ue && !(cw && cm[0]);
        keep_ce = m_ce && !(cw && cm[1]);
        hit_a   = v && (ea != 2'b00);
        hit_b   = v && (eb != 2'b00);
        m_berr  = v && (a[3] ? eb[1] : ea[1]);
        if ((hit_a || hit_b) && !keep_ue && !keep_ce)
            m_addr = {a[31:4], 4'h0} + (hit_a ? 32'd0 : 32'd8);
        m_ue = keep_ue || (v && (ea[1] || eb[1]));
        m_ce = keep_ce || (v && (ea == 2'b01 || eb == 2'b01));
        #(PERIOD/4);
        compare_all(tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * LIMIT);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, LIMIT);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        rst_n = 1'b1;
        compare_all("R1");

        // R3: clean read, no bus error
        step(1, 32'h0003_0000, 2'b00, 2'b00, 0, 2'b00, "R3");
        // R2 R3 R6: fatal in B while A is addressed
        step(1, 32'h0003_0004, 2'b00, 2'b10, 0, 2'b00, "R2");
        step(0, 32'h0, 2'b00, 2'b00, 0, 2'b00, "R3");
        // R3 R8: addressed B fatal, address held
        step(1, 32'h0003_0008, 2'b00, 2'b11, 0, 2'b00, "R8");
        // R4: flag persists without clear
        step(0, 32'h0, 2'b00, 2'b00, 0, 2'b00, "R4");
        step(0, 32'h0, 2'b00, 2'b00, 1, 2'b10, "R4");
        step(0, 32'h0, 2'b00, 2'b00, 1, 2'b01, "R4");
        // R5 R7: both halves corrected, B addressed
        step(1, 32'h0004_000C, 2'b01, 2'b01, 0, 2'b00, "R7");
        // R11: fatal in A addressed while correction flag set
        step(1, 32'h0005_0002, 2'b10, 2'b00, 0, 2'b00, "R11");
        step(0, 32'h0, 2'b00, 2'b00, 1, 2'b10, "R11");
        // R9: clear races a new fatal error in B, A addressed
        step(1, 32'h0006_0000, 2'b00, 2'b10, 1, 2'b01, "R9");
        // R10: idle cycles carrying error verdicts
        step(0, 32'h0007_0008, 2'b10, 2'b11, 0, 2'b00, "R10");
        step(0, 32'h0007_0000, 2'b01, 2'b01, 0, 2'b00, "R10");
        // R8: clear all with no new event keeps the address
        step(0, 32'h0, 2'b00, 2'b00, 1, 2'b11, "R8");
        // R6 R5: corrected only in B, A addressed
        step(1, 32'h0008_0000, 2'b00, 2'b01, 0, 2'b00, "R6");
        // R9: correction-clear races a fatal in A
        step(1, 32'h0009_0008, 2'b11, 2'b00, 1, 2'b10, "R9");
        step(0, 32'h0, 2'b00, 2'b00, 1, 2'b11, "R4");

        // R2: random traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            step(($urandom_range(0, 3) != 0), a,
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)), "R2");
        end
        finish_run();
    end

endmodule